// File: doc/BRIEF.md
# Implicit-Length Packed String Comparator

This block compares two short strings packed into wide operands and reports, for each element position, whether a chosen matching rule holds. Each operand carries either byte or 16-bit word elements. A string's length is not passed in: it ends at its first zero element. Every element is tagged valid or invalid on that basis. Every element of the second operand is then compared against every element of the first, and the comparison matrix is reduced by one of four rules: match-any-of-set, in-range, position-by-position equality, or ordered substring search.

The reduced vector can then be inverted, either fully or only where the second string is valid. The result is returned either as a packed bit vector in the low bits of the mask output or as a mask widened to one all-ones or all-zeros element per position. Six status flags describe the result and report whether each operand held a terminating zero. The datapath is combinational from operand to result, with one register stage on the outputs.

Top module: `strcmp_implicit`

## Requirements
- R1: Element i of an operand is valid only when every element at index 0..i is nonzero; the lowest zero element and everything above it are invalid, and an operand with no zero element is entirely valid.
- R2: ctrl[0] selects the element size: 0 gives bytes (element i at bits 8i+7:8i), 1 gives 16-bit words (element i at bits 16i+15:16i), with DATA_W/8 or DATA_W/16 elements per operand.
- R3: With ctrl[3:2]=00, result bit j is 1 when valid element j of op_b equals any valid element of op_a.
- R4: With ctrl[3:2]=01, result bit j is 1 when valid element j of op_b lies within some pair (op_a[2p] <= x <= op_a[2p+1]) whose two bounds are both valid; ctrl[1]=1 compares as two's complement, ctrl[1]=0 as unsigned.
- R5: With ctrl[3:2]=10, result bit i is the equality of element i of both operands when both are valid, 1 when both are invalid, and 0 when only one is valid.
- R6: With ctrl[3:2]=11, result bit j is 1 when, for every k with j+k below the element count, either op_a[k] is invalid or op_b[j+k] is valid and equal to op_a[k].
- R7: ctrl[5:4] sets polarity: 00 and 10 keep the result, 01 inverts every bit within the element count, 11 inverts only the bits whose op_b element is valid.
- R8: With ctrl[6]=0, mask holds the final result vector in its low bits (one bit per element) and zero above.
- R9: With ctrl[6]=1, each element slot of mask is all ones when its result bit is 1 and all zeros otherwise.
- R10: cf is 1 exactly when the final result vector is nonzero; of equals bit 0 of the final result vector.
- R11: zf is 1 when op_b contains a zero element within the element count, sf is 1 when op_a does; af and pf are always 0.
- R12: All outputs are registered: they reflect the inputs present at the previous rising clock edge, and a synchronous active-high reset clears mask and every flag to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | DATA_W | First string: the set, range bounds or needle |
| op_b | input | DATA_W | Second string: the text being scanned |
| ctrl | input | 8 | Size, signedness, rule, polarity and output form; bit 7 unused |
| mask | output | DATA_W | Packed or widened result |
| cf | output | 1 | Result nonzero |
| zf | output | 1 | op_b holds a zero element |
| sf | output | 1 | op_a holds a zero element |
| of | output | 1 | Result bit 0 |
| af | output | 1 | Always 0 |
| pf | output | 1 | Always 0 |

## Verification
The bench builds the comparator with DATA_W=32, which gives four byte lanes or two word lanes. At that width every one of the 128 meaningful control codes is swept. Operands are drawn from a small alphabet rich in zeros, sign-bit values and repeats, so terminators at the first, middle and last position, identical strings, range bounds of either sign and partial substring overlaps at the top edge all occur many times per code. Hand-worked vectors pin down the invalid-element rules of each aggregation and both polarity inversions.

// File: rtl/strcmp_pkg.sv
package strcmp_pkg;
  localparam int KEY_W = 17;

  typedef enum logic [1:0] {
    AGG_ANY   = 2'b00,
    AGG_RANGE = 2'b01,
    AGG_EACH  = 2'b10,
    AGG_ORDER = 2'b11
  } agg_e;

  typedef enum logic [1:0] {
    POL_KEEP       = 2'b00,
    POL_FLIP       = 2'b01,
    POL_KEEP_ALT   = 2'b10,
    POL_FLIP_VALID = 2'b11
  } pol_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
    logic af;
    logic pf;
  } flags_t;
endpackage

// File: rtl/strcmp_lanes.sv
module strcmp_lanes
  import strcmp_pkg::*;
#(
  parameter int DATA_W = 128,
  localparam int NE = DATA_W / 8,
  localparam int NW = DATA_W / 16
) (
  input  logic [DATA_W-1:0]        opnd,
  input  logic                     word_mode,
  input  logic                     signed_mode,
  output logic [NE-1:0][KEY_W-1:0] key,
  output logic [NE-1:0]            in_use,
  output logic [NE-1:0]            valid,
  output logic                     has_null
);
  logic [NE-1:0] is_zero;
  logic [NE:0]   seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NE; i++) begin : g_el
    logic [7:0]  bv;
    logic [15:0] wv;
    logic        word_lane;

    assign bv = opnd[8*i +: 8];
    if (i < NW) begin : g_w
      assign wv        = opnd[16*i +: 16];
      assign word_lane = 1'b1;
    end else begin : g_nw
      assign wv        = '0;
      assign word_lane = 1'b0;
    end

    assign key[i]     = word_mode ? {signed_mode & wv[15], wv}
                                  : {{9{signed_mode & bv[7]}}, bv};
    assign in_use[i]  = word_mode ? word_lane : 1'b1;
    assign is_zero[i] = word_mode ? (word_lane && (wv == 16'h0)) : (bv == 8'h0);

    // valid while no terminator has been seen at or below this index
    assign seen[i+1]  = seen[i] | is_zero[i];
    assign valid[i]   = in_use[i] & ~seen[i] & ~is_zero[i];
  end

  assign has_null = |is_zero;
endmodule

// File: rtl/strcmp_match.sv
module strcmp_match
  import strcmp_pkg::*;
#(
  parameter int NE = 16,
  localparam int NP = NE / 2
) (
  input  logic [NE-1:0][KEY_W-1:0] a_key,
  input  logic [NE-1:0][KEY_W-1:0] b_key,
  input  logic [NE-1:0]            a_vld,
  input  logic [NE-1:0]            b_vld,
  input  logic [NE-1:0]            in_use,
  input  agg_e                     agg,
  output logic [NE-1:0]            res1
);
  // eq[j][i]: element j of b against element i of a
  logic [NE-1:0][NE-1:0] eq;
  logic [NE-1:0][NP-1:0] in_rng;
  logic [NP-1:0]         pair_ok;
  logic [NE-1:0]         any_v, rng_v, each_v, ord_v;
  logic [NE-1:0]         sel;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    assign pair_ok[p] = a_vld[2*p] & a_vld[2*p+1];
  end

  for (genvar j = 0; j < NE; j++) begin : g_row
    logic [NE-1:0] hit;

    for (genvar i = 0; i < NE; i++) begin : g_col
      assign eq[j][i] = (b_key[j] == a_key[i]);
    end

    for (genvar p = 0; p < NP; p++) begin : g_rng
      assign in_rng[j][p] = ($signed(b_key[j]) >= $signed(a_key[2*p])) &&
                            ($signed(b_key[j]) <= $signed(a_key[2*p+1]));
    end

    assign any_v[j]  = b_vld[j] & |(eq[j] & a_vld);
    assign rng_v[j]  = b_vld[j] & |(in_rng[j] & pair_ok);
    assign each_v[j] = (a_vld[j] & b_vld[j] & eq[j][j]) | (~a_vld[j] & ~b_vld[j]);

    // needle element k aligned at text position j+k
    for (genvar k = 0; k < NE; k++) begin : g_ord
      if (j + k < NE) begin : g_in
        assign hit[k] = ~in_use[j+k] | ~a_vld[k] | (b_vld[j+k] & eq[j+k][k]);
      end else begin : g_out
        assign hit[k] = 1'b1;
      end
    end
    assign ord_v[j] = &hit;
  end

  always_comb begin
    case (agg)
      AGG_ANY:   sel = any_v;
      AGG_RANGE: sel = rng_v;
      AGG_EACH:  sel = each_v;
      default:   sel = ord_v;
    endcase
    res1 = sel & in_use;
  end
endmodule

// File: rtl/strcmp_shape.sv
module strcmp_shape #(
  parameter int DATA_W = 128,
  localparam int NE = DATA_W / 8,
  localparam int NW = DATA_W / 16
) (
  input  logic [NE-1:0]     res2,
  input  logic              word_mode,
  input  logic              expand,
  output logic [DATA_W-1:0] mask_d
);
  logic [DATA_W-1:0] byte_exp;
  logic [DATA_W-1:0] word_exp;
  logic [DATA_W-1:0] packed_v;

  for (genvar i = 0; i < NE; i++) begin : g_b
    assign byte_exp[8*i +: 8] = {8{res2[i]}};
  end

  for (genvar i = 0; i < NW; i++) begin : g_w
    assign word_exp[16*i +: 16] = {16{res2[i]}};
  end

  assign packed_v = {{(DATA_W-NE){1'b0}}, res2};
  assign mask_d   = expand ? (word_mode ? word_exp : byte_exp) : packed_v;
endmodule

// File: rtl/strcmp_implicit.sv
module strcmp_implicit
  import strcmp_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [7:0]        ctrl,
  output logic [DATA_W-1:0] mask,
  output logic              cf,
  output logic              zf,
  output logic              sf,
  output logic              of,
  output logic              af,
  output logic              pf
);
  localparam int NE = DATA_W / 8;

  logic [NE-1:0][KEY_W-1:0] a_key, b_key;
  logic [NE-1:0]            a_use, b_use, lane_use;
  logic [NE-1:0]            a_vld, b_vld;
  logic                     a_null, b_null;
  logic [NE-1:0]            res1, res2;
  logic [DATA_W-1:0]        mask_d, mask_q;
  flags_t                   flags_d, flags_q;
  logic                     ctrl_unused;

  assign ctrl_unused = ctrl[7];

  strcmp_lanes #(.DATA_W(DATA_W)) u_lane_a (
    .opnd(op_a), .word_mode(ctrl[0]), .signed_mode(ctrl[1]),
    .key(a_key), .in_use(a_use), .valid(a_vld), .has_null(a_null)
  );

  strcmp_lanes #(.DATA_W(DATA_W)) u_lane_b (
    .opnd(op_b), .word_mode(ctrl[0]), .signed_mode(ctrl[1]),
    .key(b_key), .in_use(b_use), .valid(b_vld), .has_null(b_null)
  );

  assign lane_use = a_use & b_use;

  strcmp_match #(.NE(NE)) u_match (
    .a_key(a_key), .b_key(b_key), .a_vld(a_vld), .b_vld(b_vld),
    .in_use(lane_use), .agg(agg_e'(ctrl[3:2])), .res1(res1)
  );

  always_comb begin
    case (pol_e'(ctrl[5:4]))
      POL_FLIP:       res2 = ~res1 & lane_use;
      POL_FLIP_VALID: res2 = res1 ^ b_vld;
      default:        res2 = res1;
    endcase
  end

  strcmp_shape #(.DATA_W(DATA_W)) u_shape (
    .res2(res2), .word_mode(ctrl[0]), .expand(ctrl[6]), .mask_d(mask_d)
  );

  always_comb begin
    flags_d    = '0;
    flags_d.cf = |res2;
    flags_d.zf = b_null;
    flags_d.sf = a_null;
    flags_d.of = res2[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      flags_q <= '0;
    end else begin
      mask_q  <= mask_d;
      flags_q <= flags_d;
    end
  end

  assign mask = mask_q;
  assign cf   = flags_q.cf;
  assign zf   = flags_q.zf;
  assign sf   = flags_q.sf;
  assign of   = flags_q.of;
  assign af   = flags_q.af;
  assign pf   = flags_q.pf;
endmodule

// File: rtl/strcmp_implicit_chk.sv
module strcmp_implicit_chk #(
  parameter int DATA_W = 128,
  localparam int NE = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [7:0]        ctrl,
  input logic [DATA_W-1:0] mask,
  input logic              cf,
  input logic              zf,
  input logic              sf,
  input logic              of
);
  logic ctrl_unused;
  assign ctrl_unused = ^{ctrl[7], ctrl[1]};

  p_carry_r10: assert property (@(posedge clk) disable iff (rst)
    cf == (|mask));

  p_ovf_r10: assert property (@(posedge clk) disable iff (rst)
    of == mask[0]);

  p_packed_hi_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctrl[6])) |-> (mask[DATA_W-1:NE] == '0));

  for (genvar i = 0; i < NE; i++) begin : g_lane
    p_expand_lane_r9: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ctrl[6])) |->
        (mask[8*i +: 8] == 8'h00 || mask[8*i +: 8] == 8'hFF));
  end

  p_zf_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_b[15:0]) == 16'h0) |-> zf);

  p_sf_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_a[15:0]) == 16'h0) |-> sf);

  p_each_same_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl[6] == 1'b0 && ctrl[5:4] == 2'b00 &&
                          ctrl[3:2] == 2'b10 && ctrl[0] == 1'b0 && op_a == op_b))
      |-> (mask[NE-1:0] == '1));
endmodule

bind strcmp_implicit strcmp_implicit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .ctrl(ctrl),
  .mask(mask), .cf(cf), .zf(zf), .sf(sf), .of(of)
);

// File: tb/strcmp_implicit_test.sv
module strcmp_implicit_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int NB = W / 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic [7:0]   c = '0;
  logic [W-1:0] mask;
  logic         cf, zf, sf, of, af, pf;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;
  logic [31:0] rnd = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  strcmp_implicit #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst), .op_a(a), .op_b(b), .ctrl(c),
    .mask(mask), .cf(cf), .zf(zf), .sf(sf), .of(of), .af(af), .pf(pf)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // behavioural model built from the requirements
  task automatic model(input logic [W-1:0] ra, input logic [W-1:0] rb,
                       input logic [7:0] rc,
                       output logic [W-1:0] em, output logic [5:0] ef);
    int n, esz, la, lb;
    int av[NB];
    int bv[NB];
    logic [NB-1:0] r1, r2;
    n   = rc[0] ? NB/2 : NB;
    esz = rc[0] ? 16 : 8;
    la  = n;
    lb  = n;
    for (int i = 0; i < NB; i++) begin
      av[i] = 0;
      bv[i] = 0;
    end
    for (int i = 0; i < n; i++) begin
      av[i] = rc[0] ? int'(ra[16*i +: 16]) : int'(ra[8*i +: 8]);
      bv[i] = rc[0] ? int'(rb[16*i +: 16]) : int'(rb[8*i +: 8]);
      if (av[i] == 0 && la == n) la = i;
      if (bv[i] == 0 && lb == n) lb = i;
      if (rc[1] && av[i] >= (1 << (esz-1))) av[i] -= (1 << esz);
      if (rc[1] && bv[i] >= (1 << (esz-1))) bv[i] -= (1 << esz);
    end
    r1 = '0;
    for (int j = 0; j < n; j++) begin
      case (rc[3:2])
        2'b00: for (int i = 0; i < la; i++)
                 if (j < lb && bv[j] == av[i]) r1[j] = 1'b1;
        2'b01: for (int i = 0; i + 1 < la; i += 2)
                 if (j < lb && bv[j] >= av[i] && bv[j] <= av[i+1]) r1[j] = 1'b1;
        2'b10: r1[j] = (j < la && j < lb) ? (av[j] == bv[j]) : (j >= la && j >= lb);
        default: begin
          r1[j] = 1'b1;
          for (int k = 0; j + k < n; k++)
            if (k < la && (j + k >= lb || av[k] != bv[j+k])) r1[j] = 1'b0;
        end
      endcase
    end
    r2 = '0;
    for (int j = 0; j < n; j++) begin
      case (rc[5:4])
        2'b01:   r2[j] = ~r1[j];
        2'b11:   r2[j] = (j < lb) ? ~r1[j] : r1[j];
        default: r2[j] = r1[j];
      endcase
    end
    em = '0;
    if (rc[6]) begin
      for (int j = 0; j < n; j++)
        for (int q = 0; q < esz; q++) em[j*esz + q] = r2[j];
    end else begin
      em[NB-1:0] = r2;
    end
    ef = {|r2, lb < n, la < n, r2[0], 1'b0, 1'b0};
  endtask

  // drive one vector, check one clock later (R12 latency)
  task automatic run(input logic [W-1:0] ra, input logic [W-1:0] rb,
                     input logic [7:0] rc, input string tag,
                     input logic [W-1:0] xm, input logic [5:0] xf);
    @(negedge clk);
    a = ra;
    b = rb;
    c = rc;
    @(negedge clk);
    check(tag, "mask", mask, xm);
    check("R10", "cf,of", {30'd0, cf, of}, {30'd0, xf[5], xf[2]});
    check("R11", "zf,sf,af,pf", {28'd0, zf, sf, af, pf},
          {28'd0, xf[4], xf[3], xf[1], xf[0]});
  endtask

  function automatic string mode_tag(input logic [7:0] rc);
    case (rc[3:2])
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  function automatic logic [W-1:0] pick(input logic [31:0] r, input bit word);
    logic [W-1:0] v;
    logic [7:0]  ball [8];
    logic [15:0] wall [8];
    ball = '{8'h00, 8'h01, 8'h01, 8'h02, 8'h80, 8'hFF, 8'h7F, 8'h00};
    wall = '{16'h0000, 16'h0001, 16'h0100, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h0001, 16'h0101};
    v = '0;
    if (word) begin
      for (int i = 0; i < W/16; i++) v[16*i +: 16] = wall[r[3*i +: 3]];
    end else begin
      for (int i = 0; i < NB; i++) v[8*i +: 8] = ball[r[3*i +: 3]];
    end
    return v;
  endfunction

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R12 watchdog: got timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic [W-1:0] xm, va, vb;
    logic [5:0]   xf;
    logic [7:0]   cc;

    // R12: reset state
    a = 32'h0000_0000;
    b = 32'h0000_0000;
    repeat (3) @(negedge clk);
    check("R12", "reset mask", mask, 32'h0);
    check("R12", "reset flags", {26'd0, cf, zf, sf, of, af, pf}, 32'h0);
    rst = 1'b0;

    // R1, R5: terminator in the middle of both, tails both invalid -> true
    run(32'h4300_4241, 32'h4400_4241, 8'h08, "R1", 32'h0000_000F, 6'b111100);
    // R1: terminator at index 0 of op_a
    run(32'h4141_4100, 32'h4141_4141, 8'h00, "R1", 32'h0, 6'b001000);
    // R1, R3: no terminator, set membership
    run(32'h4443_4241, 32'h4141_5A43, 8'h00, "R3", 32'h0000_000D, 6'b100100);
    // R7: flip only valid positions, then flip all
    run(32'h0000_4241, 32'h0042_0041, 8'h30, "R7", 32'h0, 6'b011000);
    run(32'h0000_4241, 32'h0042_0041, 8'h10, "R7", 32'h0000_000E, 6'b111000);
    // R2, R9: word elements, widened mask
    run(32'h1234_5678, 32'h1234_5679, 8'h49, "R9", 32'hFFFF_0000, 6'b100000);
    // R4: signed versus unsigned range
    run(32'h0000_1080, 32'h7F20_F005, 8'h06, "R4", 32'h0000_0003, 6'b101100);
    run(32'h0000_1080, 32'h7F20_F005, 8'h04, "R4", 32'h0, 6'b001000);
    // R6: ordered search, including needle running past the top
    run(32'h0000_4241, 32'h4241_4241, 8'h0C, "R6", 32'h0000_0005, 6'b101100);
    run(32'h0000_4241, 32'h4142_4342, 8'h0C, "R6", 32'h0000_0008, 6'b101000);
    // R2, R8: word elements, packed result
    run(32'h0000_0041, 32'h0041_0041, 8'h01, "R8", 32'h0000_0003, 6'b101100);
    // R12: reset clears a nonzero result
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R12", "mask after reset", mask, 32'h0);
    rst = 1'b0;

    // sweep every control code against drawn operands
    for (int cv = 0; cv < 128; cv++) begin
      for (int t = 0; t < 400; t++) begin
        cc  = 8'(cv);
        rnd = step(rnd);
        va  = pick(rnd, cc[0]);
        rnd = step(rnd);
        vb  = (t % 8 == 0) ? va : pick(rnd, cc[0]);
        model(va, vb, cc, xm, xf);
        run(va, vb, cc, cc[6] ? "R9" : mode_tag(cc), xm, xf);
      end
    end

    done = 1'b1;
    finish_up();
  end
endmodule